// File: doc/BRIEF.md
# Integer Subtract and Test Execute Unit

This block is the execute stage for a handful of register-only integer operations in a 32-bit RISC pipeline. It decodes a 16-bit instruction word that holds two 5-bit register fields around a 6-bit opcode, and supports five operations: subtract, reverse subtract, flag-only AND test, byte sign extension and halfword sign extension. The two operands come from a 32-entry register file inside the block. The result, its destination index and a writeback strobe appear on the outputs one clock after the instruction strobe. The carry, overflow, sign and zero flags are held in registers.

The register file has a load port and a combinational peek port. They are there so that the surrounding logic, or a testbench, can set up operands and read results. Register 0 is hardwired to zero. Any opcode the unit does not recognise is treated as a no-op: nothing is written back and no flag changes.

Top module: `subtst_exec_unit`

## Requirements
- R1: Instruction fields are reg2 = bits 15:11, opcode = bits 10:5 and reg1 = bits 4:0. Opcode 6'b001101 writes GR[reg2] − GR[reg1] into reg2, with wbIdx = reg2.
- R2: Opcode 6'b001100 writes GR[reg1] − GR[reg2] into reg2, with wbIdx = reg2.
- R3: After either subtract, cyFlag is 1 exactly when the unsigned minuend is below the subtrahend (a borrow). ovFlag is 1 exactly when the signed 32-bit difference overflows.
- R4: After a subtract, reverse subtract or test, sFlag equals bit 31 of the result and zFlag is 1 exactly when the 32-bit result is zero.
- R5: Opcode 6'b001011 computes GR[reg2] AND GR[reg1] and sets ovFlag to 0. S and Z follow the AND result and cyFlag is unchanged. wbEn stays 0 and no register changes.
- R6: When bits 15:11 = 5'b00000 and the opcode is 6'b000101, reg1 is replaced by the sign extension of its bits 7:0, with wbIdx = reg1. No flag changes.
- R7: When bits 15:11 = 5'b00000 and the opcode is 6'b000111, reg1 is replaced by the sign extension of its bits 15:0, with wbIdx = reg1. No flag changes.
- R8: Any other opcode, and either sign-extend opcode with nonzero bits 15:11, leaves wbEn at 0 and changes no flag and no register.
- R9: Register 0 always reads as zero. Writes to it, from an instruction or from the load port, have no effect.
- R10: Results are registered. wbEn, wbIdx, wbData, the flags and the destination register take their new values on the first rising edge at which instrValid is sampled high. wbEn stays high for that one cycle only.
- R11: After reset, wbEn and all four flags are 0 and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction strobe |
| instrWord | input | 16 | Instruction word |
| loadEn | input | 1 | Register load strobe |
| loadIdx | input | 5 | Register index to load |
| loadData | input | 32 | Value to load |
| peekIdx | input | 5 | Register index to read |
| peekData | output | 32 | Combinational read of register peekIdx |
| wbEn | output | 1 | Writeback happened this cycle |
| wbIdx | output | 5 | Destination register of last writeback |
| wbData | output | 32 | Result of last writeback |
| cyFlag | output | 1 | Carry (borrow) flag |
| ovFlag | output | 1 | Overflow flag |
| sFlag | output | 1 | Sign flag |
| zFlag | output | 1 | Zero flag |

## Verification
The assertions check the following on every cycle:
- wbEn never rises without a strobe one cycle earlier.
- A test always leaves overflow clear.
- Sign extension and unrecognised encodings leave the flags untouched.
- S and Z agree with the written result after a subtract.
- Register 0 always peeks as zero.
- The subtract destination matches the reg2 field.

Only the bench's scenarios can show that the differences, borrows and overflows are arithmetically right for corner operands, that the test leaves the carry and the registers alone, and that sign extension produces the right values. They also cover the loads and writebacks to register 0.

// File: rtl/subtst_pkg.sv
package subtst_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 6;
  localparam int IDX_W   = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_EXTB = 6'b000101,
    OPC_EXTH = 6'b000111,
    OPC_TEST = 6'b001011,
    OPC_RSUB = 6'b001100,
    OPC_SUB  = 6'b001101
  } opcode_e;

  typedef struct packed {
    logic subtract;
    logic reverse;
    logic logicTest;
    logic extByte;
    logic extHalf;
    logic writeBack;
    logic arithFlags;
    logic logicFlags;
  } ctrl_t;
endpackage

// File: rtl/subtst_ctrl.sv
module subtst_ctrl
  import subtst_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrl_t              ctrl,
  output logic [IDX_W-1:0]   idxHi,
  output logic [IDX_W-1:0]   idxLo,
  output logic [IDX_W-1:0]   destIdx
);
  logic [OPC_W-1:0] opc;
  ctrl_t decoded;

  assign idxHi = instrWord[INSTR_W-1 -: IDX_W];
  assign idxLo = instrWord[IDX_W-1:0];
  assign opc   = instrWord[IDX_W +: OPC_W];

  always_comb begin
    decoded = '0;
    destIdx = idxHi;
    case (opc)
      OPC_SUB: begin
        decoded.subtract   = 1'b1;
        decoded.writeBack  = 1'b1;
        decoded.arithFlags = 1'b1;
      end
      OPC_RSUB: begin
        decoded.subtract   = 1'b1;
        decoded.reverse    = 1'b1;
        decoded.writeBack  = 1'b1;
        decoded.arithFlags = 1'b1;
      end
      OPC_TEST: begin
        decoded.logicTest  = 1'b1;
        decoded.logicFlags = 1'b1;
      end
      OPC_EXTB: begin
        destIdx = idxLo;
        if (idxHi == '0) begin
          decoded.extByte   = 1'b1;
          decoded.writeBack = 1'b1;
        end
      end
      OPC_EXTH: begin
        destIdx = idxLo;
        if (idxHi == '0) begin
          decoded.extHalf   = 1'b1;
          decoded.writeBack = 1'b1;
        end
      end
      default: decoded = '0;
    endcase
  end

  assign ctrl = instrValid ? decoded : '0;
endmodule

// File: rtl/subtst_dpath.sv
module subtst_dpath
  import subtst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] opHi,
  input  logic [DATA_W-1:0] opLo,
  input  logic [IDX_W-1:0]  destIdx,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData,
  output logic              cyFlag,
  output logic              ovFlag,
  output logic              sFlag,
  output logic              zFlag
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] minuend, subtrahend, diff, andRes, extB, extH, result;
  logic [DATA_W:0]   wideDiff;
  logic              borrow, overflow;

  assign minuend    = ctrl.reverse ? opLo : opHi;
  assign subtrahend = ctrl.reverse ? opHi : opLo;
  assign wideDiff   = {1'b0, minuend} - {1'b0, subtrahend};
  assign diff       = wideDiff[MSB:0];
  assign borrow     = wideDiff[DATA_W];
  assign overflow   = (minuend[MSB] ^ subtrahend[MSB]) & (diff[MSB] ^ minuend[MSB]);
  assign andRes     = opHi & opLo;
  assign extB       = {{(DATA_W-BYTE_W){opLo[BYTE_W-1]}}, opLo[BYTE_W-1:0]};
  assign extH       = {{(DATA_W-HALF_W){opLo[HALF_W-1]}}, opLo[HALF_W-1:0]};

  always_comb begin
    result = diff;
    if (ctrl.extByte)      result = extB;
    else if (ctrl.extHalf) result = extH;
  end

  assign wrEn   = ctrl.writeBack;
  assign wrIdx  = destIdx;
  assign wrData = result;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEn   <= 1'b0;
      wbIdx  <= '0;
      wbData <= '0;
      cyFlag <= 1'b0;
      ovFlag <= 1'b0;
      sFlag  <= 1'b0;
      zFlag  <= 1'b0;
    end else begin
      wbEn <= ctrl.writeBack;
      if (ctrl.writeBack) begin
        wbIdx  <= destIdx;
        wbData <= result;
      end
      if (ctrl.arithFlags) begin
        cyFlag <= borrow;
        ovFlag <= overflow;
        sFlag  <= diff[MSB];
        zFlag  <= (diff == '0);
      end else if (ctrl.logicFlags) begin
        ovFlag <= 1'b0;
        sFlag  <= andRes[MSB];
        zFlag  <= (andRes == '0);
      end
    end
  end
endmodule

// File: rtl/subtst_regfile.sv
module subtst_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [DATA_W-1:0] ldData,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [IDX_W-1:0]  rdIdxC,
  output logic [DATA_W-1:0] rdDataC
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                 q <= '0;
        else if (wrEn && wrIdx == IDX_W'(i))       q <= wrData;
        else if (ldEn && ldIdx == IDX_W'(i))       q <= ldData;
      end
      assign regs[i] = q;
    end
  end

  assign rdDataA = regs[rdIdxA];
  assign rdDataB = regs[rdIdxB];
  assign rdDataC = regs[rdIdxC];
endmodule

// File: rtl/subtst_exec_unit.sv
module subtst_exec_unit
  import subtst_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               loadEn,
  input  logic [IDX_W-1:0]   loadIdx,
  input  logic [DATA_W-1:0]  loadData,
  input  logic [IDX_W-1:0]   peekIdx,
  output logic [DATA_W-1:0]  peekData,
  output logic               wbEn,
  output logic [IDX_W-1:0]   wbIdx,
  output logic [DATA_W-1:0]  wbData,
  output logic               cyFlag,
  output logic               ovFlag,
  output logic               sFlag,
  output logic               zFlag
);
  ctrl_t             ctrl;
  logic [IDX_W-1:0]  idxHi, idxLo, destIdx, wrIdx;
  logic [DATA_W-1:0] opHi, opLo, wrData;
  logic              wrEn;

  subtst_ctrl u_ctrl (
    .instrValid(instrValid), .instrWord(instrWord), .ctrl(ctrl),
    .idxHi(idxHi), .idxLo(idxLo), .destIdx(destIdx)
  );

  subtst_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .ldEn(loadEn), .ldIdx(loadIdx), .ldData(loadData),
    .rdIdxA(idxHi), .rdDataA(opHi),
    .rdIdxB(idxLo), .rdDataB(opLo),
    .rdIdxC(peekIdx), .rdDataC(peekData)
  );

  subtst_dpath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opHi(opHi), .opLo(opLo),
    .destIdx(destIdx), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData),
    .cyFlag(cyFlag), .ovFlag(ovFlag), .sFlag(sFlag), .zFlag(zFlag)
  );
endmodule

// File: rtl/subtst_checker.sv
module subtst_checker (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [15:0] instrWord,
  input logic        loadEn,
  input logic [4:0]  loadIdx,
  input logic [31:0] loadData,
  input logic [4:0]  peekIdx,
  input logic [31:0] peekData,
  input logic        wbEn,
  input logic [4:0]  wbIdx,
  input logic [31:0] wbData,
  input logic        cyFlag,
  input logic        ovFlag,
  input logic        sFlag,
  input logic        zFlag
);
  logic [5:0] opc;
  logic       isSub, isTest, isExt, known;

  assign opc    = instrWord[10:5];
  assign isSub  = (opc == 6'b001101) || (opc == 6'b001100);
  assign isTest = (opc == 6'b001011);
  assign isExt  = (instrWord[15:11] == 5'd0) && ((opc == 6'b000101) || (opc == 6'b000111));
  assign known  = isSub || isTest || isExt;

  p_wb_after_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $past(instrValid));

  p_test_ov_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && isTest) |=> !ovFlag);

  p_unknown_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !known) |=> (!wbEn && $stable({cyFlag, ovFlag, sFlag, zFlag})));

  // R7 is covered by the same property
  p_ext_flags_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && isExt) |=> $stable({cyFlag, ovFlag, sFlag, zFlag}));

  p_sign_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && $past(instrValid && isSub)) |-> (sFlag == wbData[31] && zFlag == (wbData == 32'd0)));

  // R2 uses the same destination field
  p_sub_dest_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(instrValid && isSub) |-> (wbEn && wbIdx == $past(instrWord[15:11])));

  p_reg0_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (peekIdx == 5'd0) |-> (peekData == 32'd0));
endmodule

bind subtst_exec_unit subtst_checker u_chk (.*);

// File: tb/subtst_exec_unit_test.sv
`timescale 1ns/1ps
module subtst_exec_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        loadEn = 1'b0;
  logic [4:0]  loadIdx = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  peekIdx = '0;
  logic [31:0] peekData, wbData;
  logic        wbEn, cyFlag, ovFlag, sFlag, zFlag;
  logic [4:0]  wbIdx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  subtst_exec_unit uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .peekIdx(peekIdx), .peekData(peekData), .wbEn(wbEn), .wbIdx(wbIdx),
    .wbData(wbData), .cyFlag(cyFlag), .ovFlag(ovFlag), .sFlag(sFlag), .zFlag(zFlag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadReg(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = idx; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic runInstr(input logic [15:0] w);
    @(negedge clk);
    instrValid = 1'b1; instrWord = w;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic peek(input logic [4:0] idx, output logic [31:0] val);
    peekIdx = idx;
    #0.5;
    val = peekData;
  endtask

  logic [31:0] vals [8];
  logic        expCy, expOv, expS, expZ;

  task automatic flagCheck(input string tag);
    chk(cyFlag == expCy, {tag, " cy"}, 32'(cyFlag), 32'(expCy));
    chk(ovFlag == expOv, {tag, " ov"}, 32'(ovFlag), 32'(expOv));
    chk(sFlag == expS,   {tag, " s"},  32'(sFlag),  32'(expS));
    chk(zFlag == expZ,   {tag, " z"},  32'(zFlag),  32'(expZ));
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, m, s, d, a;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
    vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    vals[6] = 32'h8000_0001; vals[7] = 32'h0000_FFFF;
    expCy = 0; expOv = 0; expS = 0; expZ = 0;

    #9; rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!wbEn, "R11 wbEn", 32'(wbEn), 0);
    flagCheck("R11");
    for (int r = 0; r < 32; r++) begin
      peek(r[4:0], rd);
      chk(rd == 0, "R11 reg", rd, 0);
    end

    // R1 R2 R3 R4 R10 sweep of subtract and reverse subtract
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          loadReg(5'd2, vals[i]);
          loadReg(5'd1, vals[j]);
          m = (op == 0) ? vals[i] : vals[j];
          s = (op == 0) ? vals[j] : vals[i];
          d = m - s;
          expCy = (m < s);
          expOv = (m[31] != s[31]) && (d[31] != m[31]);
          expS = d[31]; expZ = (d == 0);
          runInstr({5'd2, (op == 0) ? 6'b001101 : 6'b001100, 5'd1});
          chk(wbEn, (op == 0) ? "R1 wbEn" : "R2 wbEn", 32'(wbEn), 1);
          chk(wbIdx == 5'd2, (op == 0) ? "R1 wbIdx" : "R2 wbIdx", 32'(wbIdx), 2);
          chk(wbData == d, (op == 0) ? "R1 result" : "R2 result", wbData, d);
          flagCheck("R3 R4 subtract");
          peek(5'd2, rd);
          chk(rd == d, "R10 reg written", rd, d);
          @(negedge clk);
          chk(!wbEn, "R10 wbEn single cycle", 32'(wbEn), 0);
        end
      end
    end

    // R5 test sweep; preset carry both ways
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        loadReg(5'd4, (j % 2 == 0) ? 32'd0 : 32'd1);
        runInstr({5'd0, 6'b001101, 5'd4});
        expCy = (j % 2 == 1); expOv = 0; expS = (j % 2 == 1); expZ = (j % 2 == 0);
        loadReg(5'd2, vals[i]);
        loadReg(5'd1, vals[j]);
        a = vals[i] & vals[j];
        expOv = 0; expS = a[31]; expZ = (a == 0);
        runInstr({5'd2, 6'b001011, 5'd1});
        chk(!wbEn, "R5 no writeback", 32'(wbEn), 0);
        flagCheck("R5 test");
        peek(5'd2, rd);
        chk(rd == vals[i], "R5 reg2 unchanged", rd, vals[i]);
        peek(5'd1, rd);
        chk(rd == vals[j], "R5 reg1 unchanged", rd, vals[j]);
      end
    end

    // R6 R7 sign extension
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] v, e;
        v = vals[i] ^ (32'h0000_0080 << (8 * k));
        e = (k == 0) ? {{24{v[7]}}, v[7:0]} : {{16{v[15]}}, v[15:0]};
        loadReg(5'd3, v);
        runInstr({5'd0, (k == 0) ? 6'b000101 : 6'b000111, 5'd3});
        chk(wbEn && wbIdx == 5'd3, (k == 0) ? "R6 dest" : "R7 dest", 32'(wbIdx), 3);
        chk(wbData == e, (k == 0) ? "R6 value" : "R7 value", wbData, e);
        peek(5'd3, rd);
        chk(rd == e, (k == 0) ? "R6 reg" : "R7 reg", rd, e);
        flagCheck((k == 0) ? "R6 flags" : "R7 flags");
      end
    end

    // R8 unrecognised encodings; flags set nonzero first
    loadReg(5'd1, 32'd1);
    runInstr({5'd0, 6'b001101, 5'd1});
    expCy = 1; expOv = 0; expS = 1; expZ = 0;
    loadReg(5'd2, 32'h0000_0081);
    loadReg(5'd1, 32'h0000_8001);
    for (int o = 0; o < 64; o++) begin
      if (o == 6'b001101 || o == 6'b001100 || o == 6'b001011) continue;
      runInstr({5'd2, o[5:0], 5'd1});
      chk(!wbEn, "R8 no writeback", 32'(wbEn), 0);
      flagCheck("R8 flags");
      peek(5'd2, rd);
      chk(rd == 32'h81, "R8 reg2", rd, 32'h81);
      peek(5'd1, rd);
      chk(rd == 32'h8001, "R8 reg1", rd, 32'h8001);
    end

    // R9 register 0
    loadReg(5'd0, 32'hDEAD_BEEF);
    peek(5'd0, rd);
    chk(rd == 0, "R9 load ignored", rd, 0);
    loadReg(5'd1, 32'h5);
    runInstr({5'd0, 6'b001100, 5'd1});
    peek(5'd0, rd);
    chk(rd == 0, "R9 write ignored", rd, 0);
    chk(wbData == 32'h5, "R9 result", wbData, 32'h5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule